// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits between the host write path of a flash bank and the bank's internal erase and program engine. It watches every write cycle aimed at the bank and recognises the protected multi-cycle command sequences: word program, sector erase, block erase, chip erase, identification entry and identification exit. When a sequence completes, it raises a single-cycle start strobe for the matching operation. Along with the strobe it presents the address and data captured from the completing cycle, plus the sector and block indices derived from that address. The engine that times the array operation is not part of this block. That engine drives a busy flag back to the decoder, and while the flag is high the decoder drops every command.

Each write is presented as a one-cycle `wr_stb` pulse with its address and data, and the decoder samples all three on the same clock edge. Any cycle that does not fit the sequence in progress sends the decoder back to the idle (read) state.

The decoder has seven states:
- ST_IDLE
- ST_GOT_AA: the first key was seen.
- ST_GOT_55: the second key was seen.
- ST_PROG_ARM: waiting for the program operand.
- ST_ERS_SETUP: the erase setup byte was seen.
- ST_ERS_AA: the first key was repeated.
- ST_ERS_55: the second key was repeated.

Its transitions are:
- ST_IDLE goes to ST_GOT_AA on AAh written at 5555h.
- ST_GOT_AA goes to ST_GOT_55 on 55h written at 2AAAh.
- From ST_GOT_55, a write at 5555h selects the next step by its data:
  - A0h goes to ST_PROG_ARM.
  - 80h goes to ST_ERS_SETUP.
  - 90h sets identification mode and returns to ST_IDLE.
  - F0h clears identification mode and returns to ST_IDLE.
- ST_PROG_ARM always returns to ST_IDLE on the next write and fires a program start.
- ST_ERS_SETUP goes to ST_ERS_AA on AAh at 5555h.
- ST_ERS_AA goes to ST_ERS_55 on 55h at 2AAAh.
- ST_ERS_55 returns to ST_IDLE on the next write and fires:
  - a sector erase on 30h at any address;
  - a block erase on 50h at any address;
  - a chip erase on 10h at 5555h.
- Every other write returns the decoder to ST_IDLE.
- A cycle with busy high returns the decoder to ST_IDLE.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all four start strobes are 0, `id_mode` is 0, and the decoder is idle.
- R2: The sequence AAh@5555h, 55h@2AAAh, A0h@5555h, followed by any write, raises `prog_start` for exactly the cycle after the clock edge of the fourth write. In that cycle `op_addr` and `op_data` hold the fourth write's address and data.
- R3: The sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address, raises `sect_erase_start` one cycle after the sixth write. `op_sector` equals address bits [ADDR_W-1:11] of that write, which gives 2K-word sectors.
- R4: The same five cycles followed by 50h at any address raise `blk_erase_start`. `op_block` equals address bits [ADDR_W-1:15] of the last write, which gives 32K-word blocks.
- R5: The same five cycles followed by 10h raise `chip_erase_start` only when the last write is at 5555h. At any other address, no strobe fires.
- R6: A write that does not match the next expected cycle returns the decoder to idle, and no strobe fires for the broken sequence. The offending write is not itself taken as the first cycle of a new sequence.
- R7: During a cycle with `busy` high, writes fire no strobe and do not change `id_mode`, and any partly entered sequence is discarded.
- R8: Only address bits [15:0] and data bits [7:0] are compared in the key and command cycles. Higher bits have no effect on recognition.
- R9: The sequence AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode` in the cycle after the third write. The same sequence with F0h clears it.
- R10: `id_word` is 00BFh when `id_mode` is 1 and `rd_addr` is 0. It is DEVICE_CODE when `id_mode` is 1 and `rd_addr` is 1. It is 0000h in every other case.
- R11: At most one start strobe is high in any cycle, and each strobe is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle pulse marking a write cycle to the flash bank |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | Internal erase or program is in progress |
| rd_addr | input | ADDR_W | Read address for identification words |
| prog_start | output | 1 | Word program start strobe |
| sect_erase_start | output | 1 | Sector erase start strobe |
| blk_erase_start | output | 1 | Block erase start strobe |
| chip_erase_start | output | 1 | Chip erase start strobe |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | DATA_W | Data of the completing write |
| op_sector | output | ADDR_W-11 | Sector index of `op_addr` |
| op_block | output | ADDR_W-15 | Block index of `op_addr` |
| id_mode | output | 1 | Identification mode is active |
| id_word | output | DATA_W | Identification word for `rd_addr` |

## Verification
The bench aims at sequences that break one cycle from completion. One case is a key repeated where a command byte belongs; a decoder that restarts on that key instead of aborting would then accept a later partial sequence and fire a stray program. A chip erase code written away from 5555h is another target: a design that ignores the address on the final erase cycle would wipe the whole array. The bench also raises busy in the middle of a sequence and sends identification exit while busy. A design that kept its state across busy would start an operation the host never fully requested, and one that let the exit through would leave identification mode early. It also sets the upper address and data bits on key cycles, which catches a compare that is too wide and would reject valid commands.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam logic [15:0] KEY_ADDR_A  = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B  = 16'h2AAA;
    localparam logic [7:0]  KEY_A       = 8'hAA;
    localparam logic [7:0]  KEY_B       = 8'h55;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_ERS_SET = 8'h80;
    localparam logic [7:0]  CMD_ID_IN   = 8'h90;
    localparam logic [7:0]  CMD_ID_OUT  = 8'hF0;
    localparam logic [7:0]  CMD_SECT    = 8'h30;
    localparam logic [7:0]  CMD_BLK     = 8'h50;
    localparam logic [7:0]  CMD_CHIP    = 8'h10;
    localparam logic [15:0] MFR_WORD    = 16'h00BF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GOT_AA,
        ST_GOT_55,
        ST_PROG_ARM,
        ST_ERS_SETUP,
        ST_ERS_AA,
        ST_ERS_55
    } fcd_state_e;

    typedef struct packed {
        logic prog;
        logic sect;
        logic blk;
        logic chip;
    } fcd_fire_t;

endpackage

// File: rtl/fcd_cycle_classify.sv
module fcd_cycle_classify #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              at_key_a,
    output logic              at_key_b,
    output logic [7:0]        code
);
    import fcd_pkg::*;

    // Only the low 16 address bits and low byte of data take part (R8)
    assign at_key_a = (addr[15:0] == KEY_ADDR_A);
    assign at_key_b = (addr[15:0] == KEY_ADDR_B);
    assign code     = data[7:0];

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              at_key_a,
    input  logic              at_key_b,
    input  logic [7:0]        code,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              blk_erase_start,
    output logic              chip_erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode
);
    import fcd_pkg::*;

    fcd_state_e state, state_nx;
    fcd_fire_t  fire;
    logic       id_set, id_clr;

    always_comb begin
        state_nx = state;
        fire     = '0;
        id_set   = 1'b0;
        id_clr   = 1'b0;
        if (busy) begin
            state_nx = ST_IDLE;
        end else if (wr_stb) begin
            state_nx = ST_IDLE;
            unique case (state)
                ST_IDLE:
                    if (at_key_a && code == KEY_A) state_nx = ST_GOT_AA;
                ST_GOT_AA:
                    if (at_key_b && code == KEY_B) state_nx = ST_GOT_55;
                ST_GOT_55:
                    if (at_key_a) begin
                        case (code)
                            CMD_PROG:    state_nx = ST_PROG_ARM;
                            CMD_ERS_SET: state_nx = ST_ERS_SETUP;
                            CMD_ID_IN:   id_set   = 1'b1;
                            CMD_ID_OUT:  id_clr   = 1'b1;
                            default:     state_nx = ST_IDLE;
                        endcase
                    end
                ST_PROG_ARM:
                    fire.prog = 1'b1;
                ST_ERS_SETUP:
                    if (at_key_a && code == KEY_A) state_nx = ST_ERS_AA;
                ST_ERS_AA:
                    if (at_key_b && code == KEY_B) state_nx = ST_ERS_55;
                ST_ERS_55:
                    case (code)
                        CMD_SECT: fire.sect = 1'b1;
                        CMD_BLK:  fire.blk  = 1'b1;
                        CMD_CHIP: fire.chip = at_key_a;
                        default:  fire      = '0;
                    endcase
                default:
                    state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_start       <= 1'b0;
            sect_erase_start <= 1'b0;
            blk_erase_start  <= 1'b0;
            chip_erase_start <= 1'b0;
            op_addr          <= '0;
            op_data          <= '0;
            id_mode          <= 1'b0;
        end else begin
            prog_start       <= fire.prog;
            sect_erase_start <= fire.sect;
            blk_erase_start  <= fire.blk;
            chip_erase_start <= fire.chip;
            if (|fire) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
            if (id_set)      id_mode <= 1'b1;
            else if (id_clr) id_mode <= 1'b0;
        end
    end

    logic any_start;
    assign any_start = prog_start | sect_erase_start | blk_erase_start | chip_erase_start;

    assert_onehot_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, sect_erase_start, blk_erase_start, chip_erase_start}));

    assert_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |=> !any_start);

    assert_busy_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !any_start);

    assert_busy_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> state == ST_IDLE);

    assert_id_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb || busy) |=> $stable(id_mode));

    assert_start_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |-> $past(wr_stb));

endmodule

// File: rtl/fcd_id_reader.sv
module fcd_id_reader #(
    parameter int          ADDR_W      = 17,
    parameter int          DATA_W      = 16,
    parameter logic [15:0] DEVICE_CODE = 16'h2789
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] id_word
);
    import fcd_pkg::*;

    always_comb begin
        id_word = '0;
        if (id_mode) begin
            if (rd_addr == '0)                id_word = DATA_W'(MFR_WORD);
            else if (rd_addr == ADDR_W'(1))   id_word = DATA_W'(DEVICE_CODE);
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int          ADDR_W      = 17,
    parameter int          DATA_W      = 16,
    parameter logic [15:0] DEVICE_CODE = 16'h2789,
    localparam int         SECT_W      = ADDR_W - 11,
    localparam int         BLK_W       = ADDR_W - 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              blk_erase_start,
    output logic              chip_erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [SECT_W-1:0] op_sector,
    output logic [BLK_W-1:0]  op_block,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_word
);

    logic       at_key_a, at_key_b;
    logic [7:0] code;

    fcd_cycle_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_classify (
        .addr     (wr_addr),
        .data     (wr_data),
        .at_key_a (at_key_a),
        .at_key_b (at_key_b),
        .code     (code)
    );

    fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_stb           (wr_stb),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .busy             (busy),
        .at_key_a         (at_key_a),
        .at_key_b         (at_key_b),
        .code             (code),
        .prog_start       (prog_start),
        .sect_erase_start (sect_erase_start),
        .blk_erase_start  (blk_erase_start),
        .chip_erase_start (chip_erase_start),
        .op_addr          (op_addr),
        .op_data          (op_data),
        .id_mode          (id_mode)
    );

    fcd_id_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEVICE_CODE(DEVICE_CODE)) u_id (
        .id_mode (id_mode),
        .rd_addr (rd_addr),
        .id_word (id_word)
    );

    // Sector and block indices of the latched operand address (R3, R4)
    assign op_sector = op_addr[ADDR_W-1:11];
    assign op_block  = op_addr[ADDR_W-1:15];

endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;

    localparam int          ADDR_W = 17;
    localparam int          DATA_W = 16;
    localparam logic [15:0] DEV    = 16'h2789;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_stb = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              busy = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              prog_start, sect_erase_start, blk_erase_start, chip_erase_start;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic [5:0]        op_sector;
    logic [1:0]        op_block;
    logic              id_mode;
    logic [DATA_W-1:0] id_word;

    always #2 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEVICE_CODE(DEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .rd_addr(rd_addr), .prog_start(prog_start),
        .sect_erase_start(sect_erase_start), .blk_erase_start(blk_erase_start),
        .chip_erase_start(chip_erase_start), .op_addr(op_addr), .op_data(op_data),
        .op_sector(op_sector), .op_block(op_block), .id_mode(id_mode), .id_word(id_word)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int m_state = 0;
    bit m_id    = 1'b0;
    bit done    = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements; ep = {prog, sect, blk, chip}
    task automatic model(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input bit b, output logic [3:0] ep);
        bit ka, kb;
        logic [7:0] c;
        ka = (a[15:0] == 16'h5555);
        kb = (a[15:0] == 16'h2AAA);
        c  = d[7:0];
        ep = 4'b0;
        if (b) begin
            m_state = 0;
        end else begin
            case (m_state)
                0: m_state = (ka && c == 8'hAA) ? 1 : 0;
                1: m_state = (kb && c == 8'h55) ? 2 : 0;
                2: begin
                    m_state = 0;
                    if (ka) begin
                        if (c == 8'hA0) m_state = 3;
                        else if (c == 8'h80) m_state = 4;
                        else if (c == 8'h90) m_id = 1'b1;
                        else if (c == 8'hF0) m_id = 1'b0;
                    end
                end
                3: begin ep[3] = 1'b1; m_state = 0; end
                4: m_state = (ka && c == 8'hAA) ? 5 : 0;
                5: m_state = (kb && c == 8'h55) ? 6 : 0;
                default: begin
                    if (c == 8'h30) ep[2] = 1'b1;
                    else if (c == 8'h50) ep[1] = 1'b1;
                    else if (c == 8'h10 && ka) ep[0] = 1'b1;
                    m_state = 0;
                end
            endcase
        end
    endtask

    function automatic logic [DATA_W-1:0] exp_id(input logic [ADDR_W-1:0] ra);
        if (!m_id) return '0;
        if (ra == 0) return 16'h00BF;
        if (ra == 1) return DEV;
        return '0;
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      input bit b, input string tag);
        logic [3:0] ep;
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d; busy = b;
        model(a, d, b, ep);
        @(negedge clk);
        wr_stb = 1'b0; busy = 1'b0;
        chk({tag, " strobes"}, {28'b0, prog_start, sect_erase_start, blk_erase_start, chip_erase_start}, {28'b0, ep});
        if (ep != 0) begin
            chk({tag, " op_addr"}, 32'(op_addr), 32'(a));
            chk({tag, " op_data"}, 32'(op_data), 32'(d));
            if (ep[2]) chk({tag, " op_sector R3"}, 32'(op_sector), 32'(a[16:11]));
            if (ep[1]) chk({tag, " op_block R4"}, 32'(op_block), 32'(a[16:15]));
        end
        chk({tag, " id_mode R9"}, 32'(id_mode), 32'(m_id));
    endtask

    task automatic idle_cyc(input bit b, input string tag);
        @(negedge clk);
        busy = b;
        if (b) m_state = 0;
        @(negedge clk);
        busy = 1'b0;
        chk({tag, " no held strobe R11"},
            {28'b0, prog_start, sect_erase_start, blk_erase_start, chip_erase_start}, 32'b0);
    endtask

    task automatic unlock(input string tag);
        wr(17'h05555, 16'h00AA, 1'b0, tag);
        wr(17'h02AAA, 16'h0055, 1'b0, tag);
    endtask

    task automatic erase_seq(input logic [7:0] c, input logic [ADDR_W-1:0] a, input string tag);
        unlock(tag);
        wr(17'h05555, 16'h0080, 1'b0, tag);
        unlock(tag);
        wr(a, {8'h00, c}, 1'b0, tag);
    endtask

    task automatic id_chk(input logic [ADDR_W-1:0] ra, input string tag);
        rd_addr = ra;
        #1;
        chk({tag, " id_word R10"}, 32'(id_word), 32'(exp_id(ra)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4513));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 strobes at reset", {28'b0, prog_start, sect_erase_start, blk_erase_start, chip_erase_start}, 32'b0);
        chk("R1 id_mode at reset", 32'(id_mode), 32'b0);
        rst_n = 1'b1;
        id_chk(17'h0, "R1");

        // R2 program
        unlock("R2");
        wr(17'h05555, 16'h00A0, 1'b0, "R2");
        wr(17'h1ABCD, 16'h1234, 1'b0, "R2 program");
        idle_cyc(1'b0, "R2");

        // R3 sector erase, R4 block erase
        erase_seq(8'h30, 17'h1F800, "R3 sector");
        erase_seq(8'h50, 17'h18000, "R4 block");

        // R5 chip erase at key address and elsewhere
        erase_seq(8'h10, 17'h05555, "R5 chip");
        erase_seq(8'h10, 17'h01234, "R5 chip wrong addr");

        // R6 a key where a command belongs aborts and does not restart
        unlock("R6");
        wr(17'h05555, 16'h00AA, 1'b0, "R6 abort");
        wr(17'h02AAA, 16'h0055, 1'b0, "R6");
        wr(17'h05555, 16'h00A0, 1'b0, "R6");
        wr(17'h00042, 16'h5A5A, 1'b0, "R6 no program");

        // R8 upper bits ignored on key cycles
        wr(17'h15555, 16'h12AA, 1'b0, "R8");
        wr(17'h12AAA, 16'hFF55, 1'b0, "R8");
        wr(17'h15555, 16'h77A0, 1'b0, "R8");
        wr(17'h00007, 16'hBEEF, 1'b0, "R8 program");

        // R7 busy mid-sequence discards it
        unlock("R7");
        idle_cyc(1'b1, "R7 busy gap");
        wr(17'h05555, 16'h00A0, 1'b0, "R7");
        wr(17'h00009, 16'h0001, 1'b0, "R7 no program");
        unlock("R7");
        wr(17'h05555, 16'h00A0, 1'b0, "R7");
        wr(17'h00009, 16'h0001, 1'b1, "R7 busy operand");

        // R9 / R10 identification entry, exit ignored while busy, then exit
        unlock("R9");
        wr(17'h05555, 16'h0090, 1'b0, "R9 enter");
        id_chk(17'h0, "R10 mfr");
        id_chk(17'h1, "R10 dev");
        id_chk(17'h2, "R10 other");
        unlock("R7");
        wr(17'h05555, 16'h00F0, 1'b1, "R7 exit while busy");
        id_chk(17'h1, "R7 still id");
        unlock("R9");
        wr(17'h05555, 16'h00F0, 1'b0, "R9 exit");
        id_chk(17'h0, "R10 after exit");

        // Constrained random sequences with occasional corruption and busy
        for (int i = 0; i < 400; i++) begin
            int kind;
            int n;
            logic [ADDR_W-1:0] ca [6];
            logic [DATA_W-1:0] cd [6];
            kind = $urandom_range(0, 5);
            ca[0] = {1'($urandom_range(0, 1)), 16'h5555}; cd[0] = {8'($urandom), 8'hAA};
            ca[1] = {1'($urandom_range(0, 1)), 16'h2AAA}; cd[1] = {8'($urandom), 8'h55};
            ca[2] = {1'($urandom_range(0, 1)), 16'h5555};
            ca[3] = ca[0]; cd[3] = cd[0];
            ca[4] = ca[1]; cd[4] = cd[1];
            ca[5] = 17'($urandom);
            cd[5] = 16'($urandom);
            n = 6;
            case (kind)
                0: begin cd[2] = 16'h00A0; ca[3] = 17'($urandom); cd[3] = 16'($urandom); n = 4; end
                1: begin cd[2] = 16'h0080; cd[5] = {8'($urandom), 8'h30}; end
                2: begin cd[2] = 16'h0080; cd[5] = {8'($urandom), 8'h50}; end
                3: begin cd[2] = 16'h0080; cd[5] = {8'($urandom), 8'h10};
                         if ($urandom_range(0, 1) == 1) ca[5] = {1'($urandom_range(0, 1)), 16'h5555}; end
                4: begin cd[2] = 16'h0090; n = 3; end
                default: begin cd[2] = 16'h00F0; n = 3; end
            endcase
            for (int j = 0; j < n; j++) begin
                logic [ADDR_W-1:0] a;
                logic [DATA_W-1:0] d;
                bit b;
                a = ca[j]; d = cd[j];
                if ($urandom_range(0, 99) < 6) begin a = 17'($urandom); d = 16'($urandom); end
                b = ($urandom_range(0, 99) < 4);
                wr(a, d, b, "random R2 R6 R7");
            end
            id_chk(17'($urandom_range(0, 2)), "random R10");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule